// File: doc/BRIEF.md
# SIMD Element Register Mapper

This block turns a vector length counted in whole registers into a stream of packed sub-word elements. A 3-bit width code selects the element size. Each register of `XLEN` bits is split into `XLEN / width` lanes. For every element index the block emits the physical register that holds it and the bit slice it occupies inside that register.

A start strobe captures a configuration. The configuration is the width code, the base register number, the vector length in registers and an active element length. The block then walks the elements in ascending order, one element per valid/ready handshake. Alongside the stream it reports the packed element count for that configuration and a flag for configurations it cannot serve. The downstream datapath that does the element arithmetic consumes this stream. The arithmetic itself is not part of the block.

Top module: `simd_elem_mapper`

## Requirements
- R1: The width code sets the element width. Code 0 selects the full register width `XLEN`, and codes 1, 2, 3, 4 and 5 select 8, 16, 32, 64 and 128 bits.
- R2: Codes 6 and 7 raise `err`, as does any code whose width exceeds `XLEN`. In that case `elem_total` reads 0, no element is emitted and `busy` stays low. `err` holds until the next accepted start.
- R3: After an accepted start, `elem_total` equals `vl_regs * (XLEN / width)`.
- R4: Element i is reported in register `base_reg + floor(i / (XLEN/width))`, taken modulo 2^REG_W.
- R5: Element i occupies bits `out_lo = (i mod (XLEN/width)) * width` up to `out_hi = out_lo + width - 1`.
- R6: The number of elements emitted is the smaller of `elem_total` and `act_len`. Trailing elements beyond `act_len` are skipped, and an `act_len` of 0 emits nothing.
- R7: Elements leave in ascending index order starting at 0, one per cycle with `out_valid` and `out_ready` both high. While `out_valid` is high and `out_ready` is low, every output field holds.
- R8: `out_last` is high on the final emitted element only. After that element is accepted, `out_valid` and `busy` fall.
- R9: A start strobe that arrives while `busy` is high is ignored. The stream in progress continues unchanged.
- R10: After reset, `out_valid`, `busy` and `err` are low and `elem_total` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture configuration and begin a walk (when idle) |
| width_code | input | 3 | Element width code |
| base_reg | input | REG_W | First physical register of the vector |
| vl_regs | input | VL_W | Vector length in registers |
| act_len | input | CNT_W | Active element length limit |
| out_valid | output | 1 | Element fields are valid |
| out_ready | input | 1 | Consumer accepts the element |
| out_reg | output | REG_W | Physical register holding the element |
| out_lo | output | BIT_W | Lowest bit of the element slice |
| out_hi | output | BIT_W | Highest bit of the element slice |
| out_idx | output | CNT_W | Element index |
| out_last | output | 1 | Final element of the walk |
| elem_total | output | CNT_W | Packed element count of the captured configuration |
| busy | output | 1 | A walk is in progress |
| err | output | 1 | Captured configuration was rejected |

## Verification
The bench goes after the cases where the packed count and the active length disagree. One case cuts off part of the last register's lanes. A mapper that ignored the limit would emit the skipped lanes, and one that applied it per register would drop whole registers. Base registers near the top of the register space check that the number wraps instead of spilling into a wider field. Full-width and 32-bit codes check that one lane per register leaves `out_lo` at 0. The 64-bit, 128-bit and reserved codes must yield `err` and an empty stream, not a truncated walk. A zero active length, a zero vector length and a start pulse in the middle of a stalled walk cover the two ways a sequencer can restart or run off the end of its count.

// File: rtl/sem_pkg.sv
// Package for the SIMD element mapper.
// Holds the width-code encoding shared by the decoder and the bench-visible behaviour.
package sem_pkg;

    // Element width codes; the numeric values are fixed by the requirements.
    typedef enum logic [2:0] {
        WC_FULL = 3'd0,
        WC_B8   = 3'd1,
        WC_B16  = 3'd2,
        WC_B32  = 3'd3,
        WC_B64  = 3'd4,
        WC_B128 = 3'd5,
        WC_RSV6 = 3'd6,
        WC_RSV7 = 3'd7
    } wcode_e;

endpackage

// File: rtl/sem_width_dec.sv
// Width decoder.
// Turns a width code into log2 of the element width and log2 of the lanes per
// register. Flags reserved codes and widths wider than the register.
// Assumes XLEN is a power of two between 8 and 128.
module sem_width_dec #(
    parameter int XLEN = 32
) (
    input  logic [2:0] code,
    output logic [3:0] ew_log2,
    output logic [3:0] epr_log2,
    output logic       bad
);
    localparam int         XL2   = $clog2(XLEN);
    localparam logic [3:0] XL2_V = 4'(XL2);

    logic [3:0] raw_log2;
    logic       rsv;

    // Map the code to a raw element-width exponent and note reserved codes.
    always_comb begin
        raw_log2 = XL2_V;
        rsv      = 1'b0;
        case (sem_pkg::wcode_e'(code))
            sem_pkg::WC_FULL: raw_log2 = XL2_V;
            sem_pkg::WC_B8,
            sem_pkg::WC_B16,
            sem_pkg::WC_B32,
            sem_pkg::WC_B64,
            sem_pkg::WC_B128: raw_log2 = {1'b0, code} + 4'd2;
            default: begin
                raw_log2 = 4'd0;
                rsv      = 1'b1;
            end
        endcase
    end

    // Reject oversize widths and derive the lane-count exponent.
    always_comb begin
        bad      = rsv || (raw_log2 > XL2_V);
        ew_log2  = bad ? 4'd0 : raw_log2;
        epr_log2 = bad ? 4'd0 : (XL2_V - raw_log2);
    end
endmodule

// File: rtl/sem_count.sv
// Element counter arithmetic.
// Computes the packed element total from the register count and the lane
// exponent, and clips it to the active length.
// Assumes CNT_W is wide enough for vl_regs times the largest lane count.
module sem_count #(
    parameter int VL_W  = 4,
    parameter int CNT_W = 6
) (
    input  logic [VL_W-1:0]  vl_regs,
    input  logic [3:0]       epr_log2,
    input  logic [CNT_W-1:0] act_len,
    output logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] eff
);
    // Packed capacity, then the smaller of capacity and active length.
    always_comb begin
        total = CNT_W'(vl_regs) << epr_log2;
        eff   = (act_len < total) ? act_len : total;
    end
endmodule

// File: rtl/sem_slice.sv
// Element slice locator.
// For one element index, gives the register number, the lowest bit and the
// highest bit of the lane the element occupies. The register number wraps
// modulo 2^REG_W. Assumes lane * width stays below XLEN, as the decoder ensures.
module sem_slice #(
    parameter int XLEN  = 32,
    parameter int REG_W = 5,
    parameter int CNT_W = 6,
    localparam int BIT_W = $clog2(XLEN)
) (
    input  logic [CNT_W-1:0] idx,
    input  logic [REG_W-1:0] base,
    input  logic [3:0]       ew_log2,
    input  logic [3:0]       epr_log2,
    output logic [REG_W-1:0] reg_num,
    output logic [BIT_W-1:0] lo,
    output logic [BIT_W-1:0] hi
);
    localparam int SW = ((CNT_W > REG_W) ? CNT_W : REG_W) + 1;
    localparam int LW = CNT_W + BIT_W + 2;

    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] grp;
    logic [CNT_W-1:0] lane;
    logic [SW-1:0]    reg_sum;
    logic [LW-1:0]    lo_w;
    logic [LW-1:0]    hi_w;

    // Split the index into register group and lane within the register.
    always_comb begin
        mask = (CNT_W'(1) << epr_log2) - CNT_W'(1);
        grp  = idx >> epr_log2;
        lane = idx & mask;
    end

    // Register number relative to the base, wrapping in REG_W bits.
    always_comb begin
        reg_sum = SW'(base) + SW'(grp);
        reg_num = reg_sum[REG_W-1:0];
    end

    // Bit slice of the lane.
    always_comb begin
        lo_w = LW'(lane) << ew_log2;
        hi_w = lo_w + (LW'(1) << ew_log2) - LW'(1);
        lo   = lo_w[BIT_W-1:0];
        hi   = hi_w[BIT_W-1:0];
    end
endmodule

// File: rtl/sem_seq.sv
// Element walk sequencer.
// Captures a configuration on start while idle. It then steps the element
// index by one on each accepted handshake until the clipped count is used up.
// A rejected configuration sets the error flag and starts no walk.
module sem_seq #(
    parameter int REG_W = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_bad,
    input  logic [CNT_W-1:0] cfg_total,
    input  logic [CNT_W-1:0] cfg_eff,
    input  logic [3:0]       cfg_ew,
    input  logic [3:0]       cfg_epr,
    input  logic [REG_W-1:0] cfg_base,
    input  logic             ready,
    output logic             valid,
    output logic             last,
    output logic [CNT_W-1:0] idx,
    output logic [CNT_W-1:0] total,
    output logic [3:0]       ew_q,
    output logic [3:0]       epr_q,
    output logic [REG_W-1:0] base_q,
    output logic             busy,
    output logic             err
);
    logic             busy_q;
    logic             err_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] eff_q;
    logic [CNT_W-1:0] total_q;
    logic             take;
    logic             fin;

    // Handshake and end-of-walk detection.
    always_comb begin
        take = busy_q && ready;
        fin  = (idx_q == (eff_q - CNT_W'(1)));
    end

    // Capture the configuration, or step the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            err_q   <= 1'b0;
            idx_q   <= '0;
            eff_q   <= '0;
            total_q <= '0;
            ew_q    <= '0;
            epr_q   <= '0;
            base_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                err_q   <= cfg_bad;
                total_q <= cfg_bad ? '0 : cfg_total;
                eff_q   <= cfg_bad ? '0 : cfg_eff;
                busy_q  <= !cfg_bad && (cfg_eff != '0);
                idx_q   <= '0;
                ew_q    <= cfg_ew;
                epr_q   <= cfg_epr;
                base_q  <= cfg_base;
            end
        end else if (take) begin
            if (fin) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + CNT_W'(1);
            end
        end
    end

    // Drive the status outputs from state.
    always_comb begin
        valid = busy_q;
        last  = busy_q && fin;
        idx   = idx_q;
        total = total_q;
        busy  = busy_q;
        err   = err_q;
    end
endmodule

// File: rtl/simd_elem_mapper.sv
// SIMD element register mapper, top level.
// Decodes the width code and sizes the walk from the live inputs. The
// sequencer captures the result on an accepted start. The captured index is
// then mapped to register and bit slice for the output stream. Outputs depend
// on registered state only, never combinationally on out_ready.
module simd_elem_mapper #(
    parameter int XLEN  = 32,
    parameter int REG_W = 5,
    parameter int VL_W  = 4,
    localparam int CNT_W = VL_W + $clog2(XLEN / 8),
    localparam int BIT_W = $clog2(XLEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       width_code,
    input  logic [REG_W-1:0] base_reg,
    input  logic [VL_W-1:0]  vl_regs,
    input  logic [CNT_W-1:0] act_len,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [REG_W-1:0] out_reg,
    output logic [BIT_W-1:0] out_lo,
    output logic [BIT_W-1:0] out_hi,
    output logic [CNT_W-1:0] out_idx,
    output logic             out_last,
    output logic [CNT_W-1:0] elem_total,
    output logic             busy,
    output logic             err
);
    logic [3:0]       d_ew;
    logic [3:0]       d_epr;
    logic             d_bad;
    logic [CNT_W-1:0] c_total;
    logic [CNT_W-1:0] c_eff;
    logic [3:0]       s_ew;
    logic [3:0]       s_epr;
    logic [REG_W-1:0] s_base;

    sem_width_dec #(.XLEN(XLEN)) u_dec (
        .code     (width_code),
        .ew_log2  (d_ew),
        .epr_log2 (d_epr),
        .bad      (d_bad)
    );

    sem_count #(.VL_W(VL_W), .CNT_W(CNT_W)) u_cnt (
        .vl_regs  (vl_regs),
        .epr_log2 (d_epr),
        .act_len  (act_len),
        .total    (c_total),
        .eff      (c_eff)
    );

    sem_seq #(.REG_W(REG_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_bad   (d_bad),
        .cfg_total (c_total),
        .cfg_eff   (c_eff),
        .cfg_ew    (d_ew),
        .cfg_epr   (d_epr),
        .cfg_base  (base_reg),
        .ready     (out_ready),
        .valid     (out_valid),
        .last      (out_last),
        .idx       (out_idx),
        .total     (elem_total),
        .ew_q      (s_ew),
        .epr_q     (s_epr),
        .base_q    (s_base),
        .busy      (busy),
        .err       (err)
    );

    sem_slice #(.XLEN(XLEN), .REG_W(REG_W), .CNT_W(CNT_W)) u_slice (
        .idx      (out_idx),
        .base     (s_base),
        .ew_log2  (s_ew),
        .epr_log2 (s_epr),
        .reg_num  (out_reg),
        .lo       (out_lo),
        .hi       (out_hi)
    );
endmodule

// File: rtl/sem_chk.sv
// Protocol checker for the SIMD element mapper, bound to the top level.
module sem_chk #(
    parameter int REG_W = 5,
    parameter int CNT_W = 6,
    parameter int BIT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [REG_W-1:0] out_reg,
    input logic [BIT_W-1:0] out_lo,
    input logic [BIT_W-1:0] out_hi,
    input logic [CNT_W-1:0] out_idx,
    input logic             out_last,
    input logic             busy,
    input logic             err
);
    // R7
    hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_reg)
                                       && $stable(out_lo) && $stable(out_hi)));

    // R7
    idx_steps_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (out_valid && out_idx == $past(out_idx) + CNT_W'(1)));

    // R8
    stop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && !busy));

    // R5
    slice_ordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hi >= out_lo));

    // R2
    no_stream_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!out_valid && !busy));
endmodule

bind simd_elem_mapper sem_chk #(.REG_W(REG_W), .CNT_W(CNT_W), .BIT_W(BIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_reg   (out_reg),
    .out_lo    (out_lo),
    .out_hi    (out_hi),
    .out_idx   (out_idx),
    .out_last  (out_last),
    .busy      (busy),
    .err       (err)
);

// File: tb/tb_simd_elem_mapper.sv
module tb_simd_elem_mapper;
    localparam int XLEN  = 32;
    localparam int REG_W = 5;
    localparam int VL_W  = 4;
    localparam int CNT_W = 6;
    localparam int BIT_W = 5;

    typedef struct {
        int reg_n;
        int lo;
        int hi;
        int idx;
        bit last;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [2:0]       width_code = '0;
    logic [REG_W-1:0] base_reg = '0;
    logic [VL_W-1:0]  vl_regs = '0;
    logic [CNT_W-1:0] act_len = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [REG_W-1:0] out_reg;
    logic [BIT_W-1:0] out_lo;
    logic [BIT_W-1:0] out_hi;
    logic [CNT_W-1:0] out_idx;
    logic             out_last;
    logic [CNT_W-1:0] elem_total;
    logic             busy;
    logic             err;

    int   checks = 0;
    int   fails = 0;
    exp_t q[$];
    logic [4:0] lfsr = 5'h13;

    simd_elem_mapper #(.XLEN(XLEN), .REG_W(REG_W), .VL_W(VL_W)) dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pick ready, then compare the element that the next edge transfers.
    always @(negedge clk) begin
        if (rst_n) begin
            bit r;
            exp_t e;
            lfsr = {lfsr[3:0], lfsr[4] ^ lfsr[2]};
            r = (lfsr[1:0] != 2'b00);
            out_ready = r;
            if (out_valid && r) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R6 extra element idx", int'(out_idx), -1);
                end else begin
                    e = q.pop_front();
                    chk(int'(out_idx) == e.idx, "R7 idx", int'(out_idx), e.idx);
                    chk(int'(out_reg) == e.reg_n, "R4 reg", int'(out_reg), e.reg_n);
                    chk(int'(out_lo) == e.lo, "R5 lo", int'(out_lo), e.lo);
                    chk(int'(out_hi) == e.hi, "R1 R5 hi", int'(out_hi), e.hi);
                    chk(out_last == e.last, "R8 last", int'(out_last), int'(e.last));
                end
            end
        end
    end

    // Driver: compute expectations, pulse start, optionally poke a second start mid-walk.
    task automatic run(input int c, input int b, input int v, input int a, input bit poke);
        int  ew;
        int  epr;
        int  tot;
        int  eff;
        bit  bad;
        int  w;
        bad = (c > 5);
        ew  = (c == 0) ? XLEN : (8 << (c - 1));
        if (ew > XLEN) bad = 1'b1;
        epr = bad ? 1 : XLEN / ew;
        tot = bad ? 0 : v * epr;
        eff = (a < tot) ? a : tot;
        for (int i = 0; i < eff; i++) begin
            exp_t e;
            e.reg_n = (b + i / epr) % 32;
            e.lo    = (i % epr) * ew;
            e.hi    = e.lo + ew - 1;
            e.idx   = i;
            e.last  = (i == eff - 1);
            q.push_back(e);
        end
        @(negedge clk);
        width_code = 3'(c);
        base_reg   = 5'(b);
        vl_regs    = 4'(v);
        act_len    = 6'(a);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == bad, "R2 err", int'(err), int'(bad));
        chk(int'(elem_total) == tot, "R3 elem_total", int'(elem_total), tot);
        if (bad || eff == 0) chk(!busy && !out_valid, "R2 R6 idle", int'(busy), 0);
        if (poke) begin
            @(negedge clk);
            width_code = 3'd0;
            base_reg   = 5'd9;
            vl_regs    = 4'd1;
            act_len    = 6'd1;
            start      = 1'b1;
            @(negedge clk);
            start = 1'b0;
            // R9: ignored start leaves the captured count alone
            chk(int'(elem_total) == tot, "R9 total kept", int'(elem_total), tot);
        end
        w = 0;
        while ((busy || q.size() != 0) && w < 2000) begin
            @(negedge clk);
            w++;
        end
        chk(q.size() == 0, "R6 count", q.size(), 0);
        @(negedge clk);
        chk(!out_valid && !busy, "R8 idle after walk", int'(out_valid), 0);
    endtask

    initial begin
        int n;
        n = 0;
        while (n < 150000) begin
            @(posedge clk);
            n++;
        end
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", n);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        chk(!out_valid && !busy && !err && elem_total == '0, "R10 reset", int'(busy), 0);
        run(1, 3, 2, 63, 1'b0);   // R1 8-bit lanes
        run(2, 4, 3, 5, 1'b0);    // R6 trailing lane skipped
        run(0, 7, 4, 63, 1'b0);   // R1 full width
        run(3, 1, 2, 63, 1'b0);   // R1 32-bit equals full
        run(1, 30, 2, 63, 1'b0);  // R4 register wrap
        run(2, 0, 15, 63, 1'b0);  // R3 long walk
        run(4, 2, 2, 63, 1'b0);   // R2 width above XLEN
        run(5, 2, 2, 63, 1'b0);   // R2 128-bit
        run(6, 2, 2, 63, 1'b0);   // R2 reserved
        run(7, 2, 2, 63, 1'b0);   // R2 reserved
        run(1, 5, 3, 0, 1'b0);    // R6 zero active length
        run(1, 5, 0, 63, 1'b0);   // R3 zero registers
        run(1, 8, 15, 63, 1'b1);  // R9 start while busy
        run(2, 6, 3, 4, 1'b0);    // R6 clip at register boundary
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule